// File: doc/BRIEF.md
# Serial Flash Instruction Receiver with SPI/QPI Mode Tracking

This block is the command entry stage of a serial flash device. It watches the chip select, serial clock and four data lines of the host bus, oversampling them with a faster system clock. It assembles the 8-bit instruction that opens every command. The interface is either in single-line mode, where the instruction arrives one bit per clock on IO0, or in four-line mode, where all four lines carry it and the instruction takes two clocks.

Each completed instruction is presented to downstream command logic as an 8-bit code with a one-cycle strobe in the system clock domain. Two instruction codes change the interface mode: 0x35 enters four-line mode and 0xF5 returns to single-line mode. Neither depends on any quad-enable setting elsewhere in the device. The change takes effect when chip select rises at the end of that command. An asynchronous reset or a synchronous soft reset input always restores single-line mode. Address, dummy and data phases are handled downstream; this block only captures the instruction and tracks the mode.

Top module: `spi_qpi_cmd_front`

## Requirements
- R1: After asynchronous reset (rst_ni low), qpi_mode_o is 0 (single-line mode) and opcode_valid_o is 0. This also holds when reset is applied while in four-line mode.
- R2: In single-line mode, the instruction is taken from io_i[0] on eight SCK rising edges while cs_ni is low, most significant bit first.
- R3: In four-line mode, the instruction is taken on two SCK rising edges. The first edge supplies bits 7:4 and the second supplies bits 3:0, with io_i[3] carrying the most significant bit of each nibble.
- R4: For each chip select period, opcode_valid_o pulses for exactly one system clock cycle, with opcode_o holding the instruction. SCK edges after the instruction in the same period produce no further pulse.
- R5: Instruction 0x35 received in single-line mode sets qpi_mode_o to 1. qpi_mode_o stays 0 until cs_ni rises at the end of that command.
- R6: Instruction 0xF5 received in four-line mode clears qpi_mode_o to 0. qpi_mode_o stays 1 until cs_ni rises at the end of that command.
- R7: Instruction 0x35 in four-line mode leaves qpi_mode_o at 1, and instruction 0xF5 in single-line mode leaves qpi_mode_o at 0.
- R8: Raising cs_ni before the instruction is complete discards the partial bits without a pulse. The next command is decoded from its first bit.
- R9: A one-cycle pulse on sync_reset_i sets qpi_mode_o to 0 and discards any partial instruction. Commands that follow are decoded in single-line mode.
- R10: Instructions are received correctly whether SCK idles low (bus mode 0) or high (bus mode 3) while cs_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_reset_i | input | 1 | Synchronous soft reset, returns to single-line mode |
| cs_ni | input | 1 | Bus chip select, active low |
| sck_i | input | 1 | Bus serial clock |
| io_i | input | 4 | Bus data lines; io_i[0] is the single-line data input |
| opcode_valid_o | output | 1 | One-cycle strobe for a completed instruction |
| opcode_o | output | 8 | Instruction code, valid with the strobe |
| qpi_mode_o | output | 1 | 1 in four-line mode, 0 in single-line mode |

## Verification
The assertions assume three things about the bus. SCK high and low phases each last several system clock cycles. Data lines are stable around each SCK rising edge. cs_ni stays low for some cycles after the last SCK edge, so that the instruction strobe and the chip select rise do not fall in the same system cycle. The bench drives SCK with half periods of six system clocks and changes data only while SCK is low. It waits a half period before raising chip select, which keeps every command within these assumptions in both bus modes.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int unsigned OPC_W    = 8;
  localparam int unsigned LANES    = 4;
  localparam int unsigned CNT_W    = $clog2(OPC_W + 1);
  localparam logic [OPC_W-1:0] OPC_ENTER_QUAD = 8'h35;
  localparam logic [OPC_W-1:0] OPC_EXIT_QUAD  = 8'hF5;

  typedef enum logic {
    IF_SINGLE = 1'b0,
    IF_QUAD   = 1'b1
  } if_mode_e;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/fe_opcode_shifter.sv
module fe_opcode_shifter
  import flash_fe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_reset_i,
  input  logic             cs_n_s_i,
  input  logic             sck_s_i,
  input  logic [LANES-1:0] io_s_i,
  input  if_mode_e         mode_i,
  output logic             valid_o,
  output logic [OPC_W-1:0] opcode_o,
  output logic             cs_rise_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  logic             sck_q, cs_q;
  logic             sck_rise, done;
  logic [OPC_W-1:0] sreg, sreg_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      cs_q  <= cs_n_s_i;
    end
  end

  // Rising edge qualified by CS low: SCK idle level is irrelevant.
  assign sck_rise  = sck_s_i & ~sck_q & ~cs_n_s_i;
  assign cs_rise_o = cs_n_s_i & ~cs_q;
  assign done      = (cnt == CNT_W'(OPC_W));

  always_comb begin
    if (mode_i == IF_QUAD) begin
      sreg_nx = {sreg[OPC_W-LANES-1:0], io_s_i};
      cnt_nx  = cnt + CNT_W'(LANES);
    end else begin
      sreg_nx = {sreg[OPC_W-2:0], io_s_i[0]};
      cnt_nx  = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      sreg     <= '0;
      valid_o  <= 1'b0;
      opcode_o <= '0;
    end else begin
      valid_o <= 1'b0;
      if (sync_reset_i || cs_n_s_i) begin
        cnt <= '0;
      end else if (sck_rise && !done) begin
        cnt  <= cnt_nx;
        sreg <= sreg_nx;
        if (cnt_nx == CNT_W'(OPC_W)) begin
          valid_o  <= 1'b1;
          opcode_o <= sreg_nx;
        end
      end
    end
  end

  assign bit_cnt_o = cnt;
endmodule

// File: rtl/fe_mode_ctrl.sv
module fe_mode_ctrl
  import flash_fe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_reset_i,
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             cs_rise_i,
  output if_mode_e         mode_o,
  output logic             pend_enter_o,
  output logic             pend_exit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o       <= IF_SINGLE;
      pend_enter_o <= 1'b0;
      pend_exit_o  <= 1'b0;
    end else if (sync_reset_i) begin
      mode_o       <= IF_SINGLE;
      pend_enter_o <= 1'b0;
      pend_exit_o  <= 1'b0;
    end else if (cs_rise_i) begin
      if (pend_enter_o) mode_o <= IF_QUAD;
      if (pend_exit_o)  mode_o <= IF_SINGLE;
      pend_enter_o <= 1'b0;
      pend_exit_o  <= 1'b0;
    end else if (valid_i) begin
      // Switch code only arms when it changes the current mode.
      pend_enter_o <= (opcode_i == OPC_ENTER_QUAD) && (mode_o == IF_SINGLE);
      pend_exit_o  <= (opcode_i == OPC_EXIT_QUAD)  && (mode_o == IF_QUAD);
    end
  end
endmodule

// File: rtl/spi_qpi_cmd_front.sv
module spi_qpi_cmd_front
  import flash_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_reset_i,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic [LANES-1:0] io_i,
  output logic             opcode_valid_o,
  output logic [OPC_W-1:0] opcode_o,
  output logic             qpi_mode_o
);
  logic             cs_n_s, sck_s;
  logic [LANES-1:0] io_s;
  logic             cs_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic             pend_enter, pend_exit;
  if_mode_e         mode;

  fe_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_n_s)
  );
  fe_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s)
  );
  fe_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(io_i), .q_o(io_s)
  );

  fe_opcode_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_reset_i(sync_reset_i),
    .cs_n_s_i    (cs_n_s),
    .sck_s_i     (sck_s),
    .io_s_i      (io_s),
    .mode_i      (mode),
    .valid_o     (opcode_valid_o),
    .opcode_o    (opcode_o),
    .cs_rise_o   (cs_rise),
    .bit_cnt_o   (bit_cnt)
  );

  fe_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_reset_i(sync_reset_i),
    .valid_i     (opcode_valid_o),
    .opcode_i    (opcode_o),
    .cs_rise_i   (cs_rise),
    .mode_o      (mode),
    .pend_enter_o(pend_enter),
    .pend_exit_o (pend_exit)
  );

  assign qpi_mode_o = (mode == IF_QUAD);
endmodule

// File: rtl/spi_qpi_cmd_front_chk.sv
module spi_qpi_cmd_front_chk #(
  parameter int unsigned OPC_W = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_reset_i,
  input logic             opcode_valid_o,
  input logic             qpi_mode_o,
  input logic             cs_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             pend_enter,
  input logic             pend_exit
);
  assert_valid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_valid_o |=> !opcode_valid_o);

  assert_no_early_switch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_valid_o |=> $stable(qpi_mode_o));

  assert_mode_change_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qpi_mode_o != $past(qpi_mode_o)) |-> ($past(cs_rise) || $past(sync_reset_i)));

  assert_pend_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pend_enter, pend_exit}));

  assert_cnt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (bit_cnt == '0));

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(OPC_W));

  assert_sync_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_reset_i |=> (!qpi_mode_o && !pend_enter && !pend_exit && bit_cnt == '0));
endmodule

bind spi_qpi_cmd_front spi_qpi_cmd_front_chk #(
  .OPC_W(flash_fe_pkg::OPC_W),
  .CNT_W(flash_fe_pkg::CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sync_reset_i  (sync_reset_i),
  .opcode_valid_o(opcode_valid_o),
  .qpi_mode_o    (qpi_mode_o),
  .cs_rise       (cs_rise),
  .bit_cnt       (bit_cnt),
  .pend_enter    (pend_enter),
  .pend_exit     (pend_exit)
);

// File: tb/spi_qpi_cmd_front_bench.sv
module spi_qpi_cmd_front_bench;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_reset = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] io = '0;
  logic       valid;
  logic [7:0] opcode;
  logic       qpi;

  int checks = 0;
  int errors = 0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  spi_qpi_cmd_front u_spi_qpi_cmd_front (
    .clk_i(clk), .rst_ni(rst_ni), .sync_reset_i(sync_reset),
    .cs_ni(cs_n), .sck_i(sck), .io_i(io),
    .opcode_valid_o(valid), .opcode_o(opcode), .qpi_mode_o(qpi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every strobe must match the head of the queue (R2 R3 R4).
  always @(negedge clk) begin
    if (rst_ni && valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected strobe", int'(opcode), 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(opcode == e, "R2/R3 opcode", int'(opcode), int'(e));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beat(input logic [3:0] d);
    @(negedge clk);
    sck = 1'b0;
    io  = d;
    wait_clk(H);
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic start_cmd(input bit mode3);
    @(negedge clk);
    sck = mode3;
    wait_clk(H);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic end_cmd(input bit mode3);
    wait_clk(H);
    sck = mode3;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(4 * H);
  endtask

  task automatic send_bits(input logic [7:0] value, input int nbits, input bit quad);
    logic [7:0] v;
    v = value;
    if (quad) begin
      for (int i = 0; i < nbits / 4; i++) begin
        beat(v[7:4]);
        v = v << 4;
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        beat({3'b000, v[7]});
        v = v << 1;
      end
    end
  endtask

  task automatic cmd(input logic [7:0] op, input bit quad, input bit mode3);
    expq.push_back(op);
    start_cmd(mode3);
    send_bits(op, 8, quad);
    end_cmd(mode3);
  endtask

  initial begin
    wait_clk(3);
    chk(qpi == 1'b0, "R1 reset mode", int'(qpi), 0);
    chk(valid == 1'b0, "R1 reset strobe", int'(valid), 0);
    rst_ni = 1'b1;
    wait_clk(4);

    // R2 R10: single-line in bus mode 0 and mode 3
    cmd(8'h9F, 1'b0, 1'b0);
    cmd(8'h03, 1'b0, 1'b1);
    cmd(8'h81, 1'b0, 1'b0);
    chk(qpi == 1'b0, "R10 mode after single cmds", int'(qpi), 0);

    // R7: exit code in single-line mode ignored
    cmd(8'hF5, 1'b0, 1'b0);
    chk(qpi == 1'b0, "R7 0xF5 ignored in single", int'(qpi), 0);

    // R5: enter quad, only after CS rises
    expq.push_back(8'h35);
    start_cmd(1'b0);
    send_bits(8'h35, 8, 1'b0);
    wait_clk(20);
    chk(qpi == 1'b0, "R5 no switch before CS rise", int'(qpi), 0);
    end_cmd(1'b0);
    chk(qpi == 1'b1, "R5 quad after 0x35", int'(qpi), 1);

    // R3: nibble order, both bus modes
    cmd(8'hA5, 1'b1, 1'b0);
    cmd(8'h5A, 1'b1, 1'b1);
    cmd(8'h8C, 1'b1, 1'b0);

    // R7: enter code in quad mode ignored
    cmd(8'h35, 1'b1, 1'b0);
    chk(qpi == 1'b1, "R7 0x35 ignored in quad", int'(qpi), 1);

    // R4: trailing nibbles in the same CS period make no strobe
    expq.push_back(8'hEB);
    start_cmd(1'b0);
    send_bits(8'hEB, 8, 1'b1);
    send_bits(8'h12, 8, 1'b1);
    send_bits(8'hF5, 8, 1'b1);
    end_cmd(1'b0);
    chk(expq.size() == 0, "R4 single strobe per CS", expq.size(), 0);
    chk(qpi == 1'b1, "R4 trailing 0xF5 not decoded", int'(qpi), 1);

    // R8: partial quad instruction aborted
    start_cmd(1'b0);
    send_bits(8'h30, 4, 1'b1);
    end_cmd(1'b0);
    cmd(8'h0B, 1'b1, 1'b0);

    // R6: exit quad, only after CS rises
    expq.push_back(8'hF5);
    start_cmd(1'b1);
    send_bits(8'hF5, 8, 1'b1);
    wait_clk(20);
    chk(qpi == 1'b1, "R6 no switch before CS rise", int'(qpi), 1);
    end_cmd(1'b1);
    chk(qpi == 1'b0, "R6 single after 0xF5", int'(qpi), 0);

    // R8: partial single-line instruction aborted
    start_cmd(1'b0);
    send_bits(8'hFF, 5, 1'b0);
    end_cmd(1'b0);
    cmd(8'h66, 1'b0, 1'b0);

    // R9: soft reset leaves quad mode and drops partial bits
    cmd(8'h35, 1'b0, 1'b0);
    chk(qpi == 1'b1, "R9 setup quad", int'(qpi), 1);
    start_cmd(1'b0);
    send_bits(8'hC0, 4, 1'b1);
    @(negedge clk);
    sync_reset = 1'b1;
    @(negedge clk);
    sync_reset = 1'b0;
    wait_clk(2);
    chk(qpi == 1'b0, "R9 soft reset to single", int'(qpi), 0);
    end_cmd(1'b0);
    cmd(8'h9F, 1'b0, 1'b1);
    chk(qpi == 1'b0, "R9 single after soft reset", int'(qpi), 0);

    // R1: async reset from quad mode
    cmd(8'h35, 1'b0, 1'b0);
    chk(qpi == 1'b1, "R1 setup quad", int'(qpi), 1);
    #1 rst_ni = 1'b0;
    #1;
    chk(qpi == 1'b0, "R1 async reset mode", int'(qpi), 0);
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(4);
    cmd(8'h05, 1'b0, 1'b0);

    wait_clk(10);
    chk(expq.size() == 0, "R4 all strobes seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule